// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is a 16-bit up-counter that alternates between two compare values. The first compare value sets how long the output stays high. The second sets how long it stays low. Each time the counter equals the active compare value, it returns to zero and the other compare value becomes active. The counter advances once per timer tick. A prescaler produces that tick by dividing the system clock by a selectable power of two.

In PWM mode the alternation drives `pwm_o`, so the two compare values set the high time and the low time of the waveform. In software timer mode the counting is the same, but the output stays low and only the pending flags report progress. Three events each have their own sticky flag: a match on the first compare value, a match on the second, and the counter wrapping from all ones to zero. Software clears a flag by writing a one to it. A per-event enable mask feeds one combined interrupt line.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset `pwm_o` is low, `pend_o` is 0 and `irq_o` is low. Write-port addresses: 0 = first compare value (high time), 1 = second compare value (low time), 2 = config, 3 = interrupt enable bits [2:0], 4 = flag clear bits [2:0]. Config bits: [3:0] = prescale select, [4] = PWM mode (1) or software timer mode (0), [5] = run.
- R2: When run starts in PWM mode, `pwm_o` is high for (C1+1)*2^sel system clocks. It is then low for (C2+1)*2^sel clocks, and the two phases keep alternating.
- R3: When both compare values are equal, the high and low times are equal, giving a square wave.
- R4: The prescale select values 0 to 8 give a timer tick every 2^sel system clocks. A select above 8 acts as 8.
- R5: A compare value of 0 gives a phase one tick long.
- R6: A compare value written while the timer runs leaves the current phase unchanged and applies to that register's next phase.
- R7: In software timer mode `pwm_o` stays low while the match flags keep being set.
- R8: Pending bit 0 sets on a first-compare match, bit 1 on a second-compare match and bit 2 on a counter overflow.
- R9: The overflow flag sets on the tick that takes the counter from FFFFh to 0000h, and not before.
- R10: Writing a one to a clear bit clears that flag on the capturing edge. If the flag's event occurs on that same edge, the flag stays set. Otherwise flags hold.
- R11: `irq_o` is high exactly when some pending bit and its enable bit are both set.
- R12: Clearing run forces `pwm_o` low, sets the counter to zero and makes the first compare value active again. A restart then begins with a full high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| pwm_o | output | 1 | PWM waveform |
| irq_o | output | 1 | Combined masked interrupt |
| pend_o | output | 3 | Pending flags {overflow, second match, first match} |

## Verification
A write takes effect on the clock edge that captures it. A match changes `pwm_o` and `pend_o` on the edge at which the counter equals the active value and a tick is present. With a prescale select of s, the first tick after run starts lands on edge 2^s. The bench drives and samples only on falling edges. It measures each phase by counting the consecutive falling-edge samples that show the same output level, and compares the count with (C+1)*2^s. For the flag cases (set wins, overflow) it waits an exact number of falling edges, so that the clear write or the check falls on the edge where the event is due or on the one just after it.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic {PH_HI = 1'b0, PH_LO = 1'b1} phase_e;

  localparam int EV_HI  = 0;
  localparam int EV_LO  = 1;
  localparam int EV_OVF = 2;
  localparam int EV_N   = 3;

  localparam logic [2:0] A_CMP_HI = 3'd0;
  localparam logic [2:0] A_CMP_LO = 3'd1;
  localparam logic [2:0] A_CFG    = 3'd2;
  localparam logic [2:0] A_IE     = 3'd3;
  localparam logic [2:0] A_CLR    = 3'd4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_MAX = 8,
  parameter int SEL_W   = $clog2(PSC_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(PSC_MAX);

  logic [PSC_MAX-1:0] div_q;
  logic [PSC_MAX-1:0] mask;
  logic [SEL_W-1:0]   sel_c;

  assign sel_c = (sel_i > SEL_TOP) ? SEL_TOP : sel_i;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PSC_MAX; i++) mask[i] = (i < int'(sel_c));
  end

  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_hi_i,
  input  logic [CNT_W-1:0] cmp_lo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_o,
  output phase_e           phase_o,
  output logic             match_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, act_q;
  phase_e           phase_q;

  assign match_o = run_i && tick_i && (cnt_q == act_q);
  assign ovf_o   = run_i && tick_i && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      act_q   <= '0;
      phase_q <= PH_HI;
    end else if (!run_i) begin
      cnt_q   <= '0;
      act_q   <= cmp_hi_i;
      phase_q <= PH_HI;
    end else if (match_o) begin
      cnt_q   <= '0;
      act_q   <= (phase_q == PH_HI) ? cmp_lo_i : cmp_hi_i;
      phase_q <= (phase_q == PH_HI) ? PH_LO : PH_HI;
    end else if (tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign act_o   = act_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ie_i);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_MAX = 8,
  parameter int ADDR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              pwm_o,
  output logic              irq_o,
  output logic [EV_N-1:0]   pend_o
);
  localparam int SEL_W    = $clog2(PSC_MAX + 1);
  localparam int CFG_MODE = SEL_W;
  localparam int CFG_RUN  = SEL_W + 1;

  logic [CNT_W-1:0] cmp_hi_q, cmp_lo_q;
  logic [SEL_W-1:0] sel_q;
  logic             pwm_mode_q, run_q;
  logic [EV_N-1:0]  ie_q, clr, ev_set;
  logic             tick, match, ovf;
  logic [CNT_W-1:0] cnt, act;
  phase_e           phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_hi_q   <= '0;
      cmp_lo_q   <= '0;
      sel_q      <= '0;
      pwm_mode_q <= 1'b0;
      run_q      <= 1'b0;
      ie_q       <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_W'(A_CMP_HI): cmp_hi_q <= wr_data_i;
        ADDR_W'(A_CMP_LO): cmp_lo_q <= wr_data_i;
        ADDR_W'(A_CFG): begin
          sel_q      <= wr_data_i[SEL_W-1:0];
          pwm_mode_q <= wr_data_i[CFG_MODE];
          run_q      <= wr_data_i[CFG_RUN];
        end
        ADDR_W'(A_IE):     ie_q <= wr_data_i[EV_N-1:0];
        default: ;
      endcase
    end
  end

  assign clr = (wr_en_i && wr_addr_i == ADDR_W'(A_CLR)) ? wr_data_i[EV_N-1:0] : '0;

  tmr_prescaler #(.PSC_MAX(PSC_MAX), .SEL_W(SEL_W)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .sel_i (sel_q),
    .tick_o(tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .tick_i  (tick),
    .cmp_hi_i(cmp_hi_q),
    .cmp_lo_i(cmp_lo_q),
    .cnt_o   (cnt),
    .act_o   (act),
    .phase_o (phase),
    .match_o (match),
    .ovf_o   (ovf)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_HI]  = match && (phase == PH_HI);
    ev_set[EV_LO]  = match && (phase == PH_LO);
    ev_set[EV_OVF] = ovf;
  end

  tmr_flags #(.N(EV_N)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ev_set),
    .clr_i (clr),
    .ie_i  (ie_q),
    .pend_o(pend_o),
    .irq_o (irq_o)
  );

  assign pwm_o = run_q && pwm_mode_q && (phase == PH_HI);
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             pwm_mode,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act,
  input logic             phase,
  input logic [2:0]       pend,
  input logic [2:0]       clr,
  input logic             pwm_o
);
  a_r12_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !pwm_o);

  a_r12_stop_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (cnt == '0 && !phase));

  a_r7_sw_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !pwm_mode) |-> !pwm_o);

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt <= act));

  a_r3_phase_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == act) |=> (phase != $past(phase) && cnt == '0));

  a_r8_hi_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == act && !phase) |=> pend[0]);

  a_r9_ovf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == {CNT_W{1'b1}}) |=> pend[2]);

  for (genvar i = 0; i < 3; i++) begin : g_hold
    a_r10_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend[i] && !clr[i]) |=> pend[i]);
  end
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run     (run_q),
  .pwm_mode(pwm_mode_q),
  .tick    (tick),
  .cnt     (cnt),
  .act     (act),
  .phase   (phase),
  .pend    (pend_o),
  .clr     (clr),
  .pwm_o   (pwm_o)
);

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        pwm_o, irq_o;
  logic [2:0]  pend_o;

  int total = 0;
  int bad = 0;

  dual_cmp_timer u_dual_cmp_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pwm_o(pwm_o), .irq_o(irq_o), .pend_o(pend_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called on a falling edge; captured on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic cfg(input int sel, input bit pwm, input bit run);
    wr(3'd2, 16'(sel) | (16'(pwm) << 4) | (16'(run) << 5));
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    while (pwm_o == lvl && n < 100000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    chk("R1 pwm", pwm_o, 0);
    chk("R1 pend", pend_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_pwm_basic();
    int n;
    wr(3'd0, 16'd3); wr(3'd1, 16'd5);
    cfg(0, 1, 1);
    measure(1'b1, n); chk("R2 high", n, 4);
    measure(1'b0, n); chk("R2 low", n, 6);
    measure(1'b1, n); chk("R2 high again", n, 4);
    repeat (2) @(negedge clk_i);
    cfg(0, 1, 0);
    chk("R12 stopped low", pwm_o, 0);
    repeat (3) @(negedge clk_i);
    cfg(0, 1, 1);
    measure(1'b1, n); chk("R12 restart full high", n, 4);
    cfg(0, 1, 0);
    wr(3'd4, 16'h7);
    chk("R10 clear all", pend_o, 0);
  endtask

  task automatic t_square();
    int n;
    wr(3'd0, 16'd2); wr(3'd1, 16'd2);
    cfg(1, 1, 1);
    measure(1'b1, n); chk("R3 R4 high div2", n, 6);
    measure(1'b0, n); chk("R3 R4 low div2", n, 6);
    cfg(1, 1, 0);
  endtask

  task automatic t_zero_and_max();
    int n;
    wr(3'd0, 16'd0); wr(3'd1, 16'd2);
    cfg(0, 1, 1);
    measure(1'b1, n); chk("R5 zero high one tick", n, 1);
    measure(1'b0, n); chk("R5 low", n, 3);
    cfg(0, 1, 0);
    wr(3'd1, 16'd0);
    cfg(8, 1, 1);
    measure(1'b1, n); chk("R4 R5 div256 high", n, 256);
    measure(1'b0, n); chk("R4 R5 div256 low", n, 256);
    cfg(8, 1, 0);
    cfg(15, 1, 1);
    measure(1'b1, n); chk("R4 sel clamp", n, 256);
    cfg(0, 1, 0);
  endtask

  task automatic t_shadow();
    int n;
    wr(3'd0, 16'd3); wr(3'd1, 16'd3);
    cfg(0, 1, 1);
    measure(1'b1, n); chk("R6 first high", n, 4);
    wr(3'd0, 16'd7);
    measure(1'b0, n); chk("R6 low untouched", n + 1, 4);
    measure(1'b1, n); chk("R6 new high", n, 8);
    cfg(0, 1, 0);
    wr(3'd4, 16'h7);
  endtask

  task automatic t_sw_mode();
    int hi = 0;
    wr(3'd0, 16'd2); wr(3'd1, 16'd2);
    cfg(0, 0, 1);
    for (int i = 0; i < 20; i++) begin
      if (pwm_o) hi++;
      @(negedge clk_i);
    end
    chk("R7 no toggle", hi, 0);
    cfg(0, 0, 0);
    chk("R7 R8 match flags", pend_o, 3);
  endtask

  task automatic t_irq();
    chk("R11 masked", irq_o, 0);
    wr(3'd3, 16'h2);
    chk("R11 lo enabled", irq_o, 1);
    wr(3'd4, 16'h2);
    chk("R10 clear lo", pend_o, 1);
    chk("R11 after clear", irq_o, 0);
    wr(3'd3, 16'h7);
    chk("R11 hi enabled", irq_o, 1);
    wr(3'd3, 16'h0);
  endtask

  task automatic t_set_wins();
    wr(3'd0, 16'd4); wr(3'd1, 16'd4);
    cfg(0, 1, 1);
    repeat (4) @(negedge clk_i);
    wr(3'd4, 16'h1);
    chk("R10 set wins", pend_o[0], 1);
    wr(3'd4, 16'h1);
    chk("R10 plain clear", pend_o, 0);
    cfg(0, 1, 0);
  endtask

  task automatic t_overflow();
    wr(3'd4, 16'h7);
    wr(3'd0, 16'hFFFF); wr(3'd1, 16'd1);
    cfg(0, 1, 1);
    repeat (65535) @(negedge clk_i);
    chk("R9 no early flag", pend_o, 0);
    chk("R2 still high at FFFF", pwm_o, 1);
    @(negedge clk_i);
    chk("R8 R9 wrap flags", pend_o, 5);
    chk("R2 low after FFFF match", pwm_o, 0);
    cfg(0, 1, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pwm_basic();
    t_square();
    t_zero_and_max();
    t_shadow();
    t_sw_mode();
    t_irq();
    t_set_wins();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule